// File: doc/BRIEF.md
# Four-Channel Block-Copy DMA Controller

This block moves blocks of 32-bit words from one memory region to another on behalf of software. Each of its four channels holds a source pointer, a destination pointer, a transfer count and a control word. One shared operation register carries the global enable, and a read-only status word reports activity. Software reaches all of them through a simple 32-bit register bus. Writing a channel's control word with the right combination of bits is what launches the copy; no separate start command exists.

A launched copy is run by a single shared engine through a memory master port. The port has a read request channel, a read response and a write request channel, each using a valid/ready style. The length of a copy is the count times 32 bytes, moved as ascending words. When the last word is written, the channel's pointers step by the whole length as chosen by its mode fields, and the channel's end flag is set. Each channel has one interrupt line, driven from the end flag and the channel's interrupt enable. When several channels are waiting, the lowest-numbered one is served first.

Top module: `quad_dma_ctrl`

## Requirements
- R1: After reset, all control words, the operation register and the status word read 0, and every irq line is 0.
- R2: Register map: channel n occupies 0x10*n, with source pointer at +0x0, destination pointer at +0x4, count at +0x8 and control at +0xC. The operation register is at 0x40, and the status word is at 0x44 with busy at bit 0. Pointer and count registers read back what was written.
- R3: A control write to channel 0 or 1 stores the data ANDed with 0xFF0FFFF7.
- R4: A control write to channel 2 or 3 stores the data ANDed with 0xFF0AFFF7.
- R5: A copy is launched only if the stored control value has the end flag (bit 1) at 0 and the channel enable (bit 0) at 1, and the operation register bit 0 is 1. Otherwise nothing is copied and the end flag stays as written.
- R6: A copy is launched only when the request-source field (control bits 11:8) equals 4. Any other value copies nothing and leaves the end flag at 0.
- R7: A copy moves count*32 bytes as consecutive 32-bit words. Source word k is read from source+4k and written to destination+4k.
- R8: On completion, each pointer changes by the byte length: it increases when its mode field is 1 and decreases when it is 2, and it is unchanged for any other value. The source mode is in control bits 13:12 and the destination mode in bits 15:14.
- R9: On completion the end flag (bit 1) becomes 1. This also holds for a count of 0, which moves no data and leaves the pointers unchanged.
- R10: irq[n] is 1 exactly when channel n's end flag and interrupt enable (bit 2) are both 1.
- R11: Status bit 0 is 1 while any channel is waiting or copying. Register writes to a waiting or copying channel are ignored.
- R12: The memory port holds a request and its address stable while ready is low. A read or write stalled by the memory still completes with correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Read request accepted |
| mem_rd_addr | output | 32 | Read byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| mem_wr_valid | output | 1 | Write request valid |
| mem_wr_ready | input | 1 | Write request accepted |
| mem_wr_addr | output | 32 | Write byte address |
| mem_wr_data | output | 32 | Write data |
| irq | output | 4 | One interrupt line per channel |

## Verification
The assertions assume that the memory returns exactly one response for each accepted read, never before the request, and that pointers are word aligned. The bench memory model answers each accepted read on the following cycle, uses only aligned pointers and toggles both ready signals in a fixed pattern so that stalls occur. It issues no register write to a channel while that channel is busy, except in the scenario that checks the writes are ignored.

// File: rtl/qdma_pkg.sv
package qdma_pkg;

  localparam int unsigned BIT_DE = 0;
  localparam int unsigned BIT_TE = 1;
  localparam int unsigned BIT_IE = 2;
  localparam int unsigned RS_LO  = 8;
  localparam int unsigned SM_LO  = 12;
  localparam int unsigned DM_LO  = 14;
  localparam logic [3:0]  RS_AUTO = 4'd4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RWAIT,
    S_WR,
    S_DONE
  } eng_state_t;

  // store mask of a control write; upper channels lack two mode bits
  function automatic logic [31:0] ctrl_mask(int unsigned ch);
    return (ch < 2) ? 32'hFF0F_FFF7 : 32'hFF0A_FFF7;
  endfunction

  // byte length of a copy: count units are 32 bytes
  function automatic logic [31:0] span_bytes(logic [31:0] cnt);
    return cnt << 5;
  endfunction

  // post-copy pointer stepping
  function automatic logic [31:0] step_addr(logic [31:0] a, logic [31:0] len,
                                            logic [1:0] mode);
    case (mode)
      2'd1:    return a + len;
      2'd2:    return a - len;
      default: return a;
    endcase
  endfunction

endpackage

// File: rtl/qdma_chan.sv
module qdma_chan
  import qdma_pkg::*;
#(
  parameter int unsigned CH_IDX = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_sel,
  input  logic [31:0] wr_data,
  input  logic        glob_en,
  input  logic        done_hit,
  output logic [31:0] sar_q,
  output logic [31:0] dar_q,
  output logic [31:0] cnt_q,
  output logic [31:0] ctrl_q,
  output logic        pend_q,
  output logic        irq
);

  localparam logic [31:0] MASK = ctrl_mask(CH_IDX);

  logic [31:0] masked;
  logic        wr_ok;
  logic        ctrl_wr;
  logic        trig;
  logic [31:0] len;

  assign masked  = wr_data & MASK;
  assign wr_ok   = wr_en && !pend_q;
  assign ctrl_wr = wr_ok && (wr_sel == 2'd3);
  assign trig    = ctrl_wr && !masked[BIT_TE] && masked[BIT_DE] && glob_en
                   && (masked[RS_LO+:4] == RS_AUTO);
  assign len     = span_bytes(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      pend_q <= 1'b0;
    end else if (done_hit) begin
      ctrl_q[BIT_TE] <= 1'b1;
      pend_q         <= 1'b0;
    end else if (ctrl_wr) begin
      ctrl_q <= masked;
      pend_q <= trig;
    end
  end

  // pointers and count carry no reset value
  always_ff @(posedge clk) begin
    if (done_hit) begin
      sar_q <= step_addr(sar_q, len, ctrl_q[SM_LO+:2]);
      dar_q <= step_addr(dar_q, len, ctrl_q[DM_LO+:2]);
    end else if (wr_ok) begin
      case (wr_sel)
        2'd0:    sar_q <= wr_data;
        2'd1:    dar_q <= wr_data;
        2'd2:    cnt_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign irq = ctrl_q[BIT_TE] & ctrl_q[BIT_IE];

  p_te_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> ctrl_q[BIT_TE]);

  p_rs_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> (ctrl_q[RS_LO+:4] == RS_AUTO) && ctrl_q[BIT_DE] && !ctrl_q[BIT_TE]);

  p_glob_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend_q) |-> $past(glob_en));

  p_ignore_active_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && wr_en && (wr_sel == 2'd0) && !done_hit) |=> $stable(sar_q));

  p_irq_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done_hit |=> (irq == ctrl_q[BIT_IE]));

endmodule

// File: rtl/qdma_engine.sv
module qdma_engine
  import qdma_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        pend,
  input  logic [NCH-1:0][31:0]  sar_v,
  input  logic [NCH-1:0][31:0]  dar_v,
  input  logic [NCH-1:0][31:0]  cnt_v,
  output logic [NCH-1:0]        done_vec,
  output logic                  running,
  output logic                  rd_valid,
  input  logic                  rd_ready,
  output logic [31:0]           rd_addr,
  input  logic                  rsp_valid,
  input  logic [31:0]           rsp_data,
  output logic                  wr_valid,
  input  logic                  wr_ready,
  output logic [31:0]           wr_addr,
  output logic [31:0]           wr_data
);

  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned LW  = 35;

  eng_state_t     st;
  logic [CHW-1:0] cur;
  logic [CHW-1:0] pick;
  logic [31:0]    rd_ptr;
  logic [31:0]    wr_ptr;
  logic [LW-1:0]  left;
  logic [31:0]    buf_q;
  logic           last_word;

  // lowest-numbered waiting channel wins
  always_comb begin
    pick = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (pend[i]) pick = CHW'(i);
    end
  end

  assign last_word = (left == LW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cur    <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
      left   <= '0;
      buf_q  <= '0;
    end else begin
      case (st)
        S_IDLE: if (|pend) begin
          cur    <= pick;
          rd_ptr <= sar_v[pick];
          wr_ptr <= dar_v[pick];
          left   <= {cnt_v[pick], 3'b000};
          st     <= (cnt_v[pick] == 32'd0) ? S_DONE : S_RD;
        end
        S_RD: if (rd_ready) st <= S_RWAIT;
        S_RWAIT: if (rsp_valid) begin
          buf_q <= rsp_data;
          st    <= S_WR;
        end
        S_WR: if (wr_ready) begin
          rd_ptr <= rd_ptr + 32'd4;
          wr_ptr <= wr_ptr + 32'd4;
          left   <= left - LW'(1);
          st     <= last_word ? S_DONE : S_RD;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    done_vec = '0;
    if (st == S_DONE) done_vec[cur] = 1'b1;
  end

  assign running  = (st != S_IDLE);
  assign rd_valid = (st == S_RD);
  assign rd_addr  = rd_ptr;
  assign wr_valid = (st == S_WR);
  assign wr_addr  = wr_ptr;
  assign wr_data  = buf_q;

  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_addr));

  p_wr_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  p_one_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_vec));

  p_word_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (wr_addr == $past(wr_addr) + 32'd4));

endmodule

// File: rtl/quad_dma_ctrl.sv
module quad_dma_ctrl
  import qdma_pkg::*;
#(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wen,
  input  logic [6:0]     reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic [31:0]    reg_rdata,
  output logic           mem_rd_valid,
  input  logic           mem_rd_ready,
  output logic [31:0]    mem_rd_addr,
  input  logic           mem_rsp_valid,
  input  logic [31:0]    mem_rsp_data,
  output logic           mem_wr_valid,
  input  logic           mem_wr_ready,
  output logic [31:0]    mem_wr_addr,
  output logic [31:0]    mem_wr_data,
  output logic [NCH-1:0] irq
);

  logic [NCH-1:0][31:0] sar_a;
  logic [NCH-1:0][31:0] dar_a;
  logic [NCH-1:0][31:0] cnt_a;
  logic [NCH-1:0][31:0] ctrl_a;
  logic [NCH-1:0]       pend;
  logic [NCH-1:0]       done_vec;
  logic [NCH-1:0]       ch_wen;
  logic [31:0]          op_q;
  logic                 running;
  logic                 busy;
  logic                 op_hit;

  assign op_hit = reg_wen && (reg_addr == 7'h40);

  always_ff @(posedge clk) begin
    if (!rst_n)      op_q <= '0;
    else if (op_hit) op_q <= reg_wdata;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_wen[g] = reg_wen && !reg_addr[6] && (reg_addr[5:4] == 2'(g));
    qdma_chan #(.CH_IDX(g)) u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (ch_wen[g]),
      .wr_sel  (reg_addr[3:2]),
      .wr_data (reg_wdata),
      .glob_en (op_q[0]),
      .done_hit(done_vec[g]),
      .sar_q   (sar_a[g]),
      .dar_q   (dar_a[g]),
      .cnt_q   (cnt_a[g]),
      .ctrl_q  (ctrl_a[g]),
      .pend_q  (pend[g]),
      .irq     (irq[g])
    );
  end

  qdma_engine #(.NCH(NCH)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .sar_v    (sar_a),
    .dar_v    (dar_a),
    .cnt_v    (cnt_a),
    .done_vec (done_vec),
    .running  (running),
    .rd_valid (mem_rd_valid),
    .rd_ready (mem_rd_ready),
    .rd_addr  (mem_rd_addr),
    .rsp_valid(mem_rsp_valid),
    .rsp_data (mem_rsp_data),
    .wr_valid (mem_wr_valid),
    .wr_ready (mem_wr_ready),
    .wr_addr  (mem_wr_addr),
    .wr_data  (mem_wr_data)
  );

  assign busy = running | (|pend);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[6]) begin
      case (reg_addr[5:2])
        4'd0:    reg_rdata = op_q;
        4'd1:    reg_rdata = {31'd0, busy};
        default: reg_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (reg_addr[5:4] == 2'(i)) begin
          case (reg_addr[3:2])
            2'd0:    reg_rdata = sar_a[i];
            2'd1:    reg_rdata = dar_a[i];
            2'd2:    reg_rdata = cnt_a[i];
            default: reg_rdata = ctrl_a[i];
          endcase
        end
      end
    end
  end

  p_done_when_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (|done_vec) |-> busy);

  p_no_mem_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_rd_valid && !mem_wr_valid);

endmodule

// File: tb/quad_dma_ctrl_tb.sv
module quad_dma_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wen = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        rd_valid, rd_ready, rsp_valid, wr_valid, wr_ready;
  logic [31:0] rd_addr, rsp_data, wr_addr, wr_data;
  logic [3:0]  irq;
  logic [3:0]  tick = '0;
  logic [31:0] mem [256];
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  quad_dma_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_rd_valid(rd_valid), .mem_rd_ready(rd_ready), .mem_rd_addr(rd_addr),
    .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data),
    .mem_wr_valid(wr_valid), .mem_wr_ready(wr_ready), .mem_wr_addr(wr_addr),
    .mem_wr_data(wr_data), .irq(irq)
  );

  // memory model with periodic stalls
  assign rd_ready = (tick[1:0] != 2'b11);
  assign wr_ready = (tick[2:1] != 2'b10);

  initial begin
    rsp_valid = 1'b0;
    rsp_data  = '0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hC0DE_0000 + i;
  end

  always @(posedge clk) begin
    tick      <= tick + 4'd1;
    rsp_valid <= 1'b0;
    if (rd_valid && rd_ready) begin
      rsp_valid <= 1'b1;
      rsp_data  <= mem[rd_addr[9:2]];
    end
    if (wr_valid && wr_ready) mem[wr_addr[9:2]] <= wr_data;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int n = 0; n < 2000; n++) begin
      rd(7'h44, s);
      if (s[0] == 1'b0) break;
    end
  endtask

  task automatic chk_copy(input string tag, input int src, input int dst, input int words);
    for (int k = 0; k < words; k++)
      chk(tag, mem[(dst >> 2) + k], 32'hC0DE_0000 + (src >> 2) + k);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int c = 0; c < 4; c++) begin
      rd(7'(c * 16 + 12), v);
      chk("R1 ctrl reset", v, 32'h0);
    end
    rd(7'h40, v); chk("R1 op reset", v, 32'h0);
    rd(7'h44, v); chk("R1 status reset", v, 32'h0);
    chk("R1 irq reset", {28'd0, irq}, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    wr(7'h0C, 32'hFFFF_FFFF);
    rd(7'h0C, v); chk("R3 ch0 mask", v, 32'hFF0F_FFF7);
    wr(7'h1C, 32'hFFFF_FFFF);
    rd(7'h1C, v); chk("R3 ch1 mask", v, 32'hFF0F_FFF7);
    wr(7'h2C, 32'hFFFF_FFFF);
    rd(7'h2C, v); chk("R4 ch2 mask", v, 32'hFF0A_FFF7);
    wr(7'h3C, 32'hFFFF_FFFF);
    rd(7'h3C, v); chk("R4 ch3 mask", v, 32'hFF0A_FFF7);
    chk("R10 irq with TE and IE", {28'd0, irq}, 32'hF);
    for (int c = 0; c < 4; c++) wr(7'(c * 16 + 12), 32'h0);
    chk("R10 irq cleared", {28'd0, irq}, 32'h0);
    wr(7'h28, 32'h1234_5678);
    rd(7'h28, v); chk("R2 count readback", v, 32'h1234_5678);
  endtask

  task automatic t_glob_off();
    logic [31:0] v;
    wr(7'h10, 32'h100); wr(7'h14, 32'h200); wr(7'h18, 32'h1);
    wr(7'h1C, 32'h5405);
    repeat (20) @(negedge clk);
    rd(7'h44, v); chk("R5 no busy when global off", v, 32'h0);
    rd(7'h1C, v); chk("R5 TE stays 0", v, 32'h5405);
    chk("R5 dest untouched", mem[32'h200 >> 2], 32'hC0DE_0000 + 32'h80);
  endtask

  task automatic t_copy_inc();
    logic [31:0] v;
    wr(7'h40, 32'h1);
    wr(7'h1C, 32'h5405);
    rd(7'h44, v); chk("R11 busy during copy", v, 32'h1);
    wait_idle();
    chk_copy("R7 R12 ch1 copy", 32'h100, 32'h200, 8);
    chk("R7 word past end untouched", mem[(32'h220 >> 2)], 32'hC0DE_0000 + 32'h88);
    rd(7'h10, v); chk("R8 src +len", v, 32'h120);
    rd(7'h14, v); chk("R8 dst +len", v, 32'h220);
    rd(7'h1C, v); chk("R9 TE set", v, 32'h5407);
    chk("R10 irq ch1", {28'd0, irq}, 32'h2);
  endtask

  task automatic t_copy_dec();
    logic [31:0] v;
    wr(7'h30, 32'h040); wr(7'h34, 32'h300); wr(7'h38, 32'h2);
    wr(7'h3C, 32'h2401);
    wait_idle();
    chk_copy("R7 ch3 copy", 32'h040, 32'h300, 16);
    rd(7'h30, v); chk("R8 src -len", v, 32'h000);
    rd(7'h34, v); chk("R8 dst fixed", v, 32'h300);
    rd(7'h3C, v); chk("R9 TE set ch3", v, 32'h2403);
    chk("R10 no irq when IE=0", {28'd0, irq[3]}, 32'h0);
  endtask

  task automatic t_rs_other();
    logic [31:0] v;
    wr(7'h00, 32'h000); wr(7'h04, 32'h3C0); wr(7'h08, 32'h1);
    wr(7'h0C, 32'h0201);
    repeat (20) @(negedge clk);
    rd(7'h0C, v); chk("R6 TE stays 0", v, 32'h0201);
    chk("R6 dest untouched", mem[32'h3C0 >> 2], 32'hC0DE_0000 + 32'hF0);
    wr(7'h0C, 32'h0403);
    repeat (10) @(negedge clk);
    chk("R5 TE written 1 no copy", mem[32'h3C0 >> 2], 32'hC0DE_0000 + 32'hF0);
  endtask

  task automatic t_ignore_active();
    logic [31:0] v;
    wr(7'h20, 32'h080); wr(7'h24, 32'h380); wr(7'h28, 32'h4);
    wr(7'h2C, 32'h5405);
    wr(7'h20, 32'hDEAD_0000);
    wr(7'h2C, 32'h0);
    wait_idle();
    chk_copy("R11 R12 ch2 copy", 32'h080, 32'h380, 32);
    rd(7'h20, v); chk("R11 src write ignored", v, 32'h100);
    rd(7'h2C, v); chk("R11 ctrl write ignored", v, 32'h5407);
  endtask

  task automatic t_zero_count();
    logic [31:0] v;
    wr(7'h00, 32'h010); wr(7'h04, 32'h020); wr(7'h08, 32'h0);
    wr(7'h0C, 32'h5405);
    wait_idle();
    rd(7'h0C, v); chk("R9 TE on zero count", v, 32'h5407);
    rd(7'h00, v); chk("R9 src unchanged", v, 32'h010);
    rd(7'h04, v); chk("R9 dst unchanged", v, 32'h020);
    chk("R9 no data moved", mem[32'h020 >> 2], 32'hC0DE_0000 + 32'h8);
    chk("R10 irq ch0", {28'd0, irq[0]}, 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%h exp=%h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_masks();
    t_glob_off();
    t_copy_inc();
    t_copy_dec();
    t_rs_other();
    t_ignore_active();
    t_zero_count();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule